// File: doc/BRIEF.md
# Halt Wakeup Oscillator-Settle Controller

This block decides which clock domains of a small controller chip run. Software writes the halt flag to stop everything: the oscillator, the core clock and the timer clock all switch off, and the watchdog is disabled. When a wakeup event arrives, the block restarts the oscillator alone. It then waits a fixed settling period, measured on the instruction-cycle clock (the oscillator divided by ten), before it gives the clock back to the rest of the chip. A lighter idle state keeps the oscillator and timer T0 running while the core is stopped. Core state is kept in idle.

A wakeup from halt can come from two sources: the multi-input wakeup line, or a rising edge on the clock-output pin. Driving the reset pin low leaves halt as well. Reset is asynchronous and returns the block to the running state at once, without the settle delay, because the chip's reset logic provides its own delay. The controller's flops run from a sampled copy of the oscillator clock, `osc_clk`. The gated domains follow the enables.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low the block is in the running state, and this takes effect at once, without waiting for a clock edge. The output word {osc_en, core_clk_en, t0_clk_en, wdog_dis, wdout_n} is then 5'b11101. Pulling `rst_n` low during halt returns the block to running at once, with no settle period.
- R2: In running, `halt_req` high at a clock edge enters halt, giving the output word 00011. `halt_req` wins over `idle_req` when both are high.
- R3: In halt, `wdout_n` is low exactly when `clkmon_en` is high. In every other state `wdout_n` is high.
- R4: In halt, `wake_mi` high at a clock edge enters the settle state, giving the output word 10011: the oscillator only, with the watchdog still disabled.
- R5: In halt, a rising edge on `clkout_pin` (low at the previous edge, high at this edge) enters settle. If the pin was already high when halt began, it does not wake the block.
- R6: The settle state lasts exactly DIV*SETTLE_COUNT edges, 2560 with the defaults. The divider is cleared when settle is entered. At the end the block returns to running, and `core_clk_en` never rises unless `osc_en` was high in the cycle before.
- R7: In running, `idle_req` high at an edge enters idle, giving the output word 10101. In idle, `wake_mi` or a `clkout_pin` rising edge returns the block to running at the next edge, with no settle period.
- R8: `halt_req` and `idle_req` are ignored in settle. `idle_req` and `halt_req` are ignored in halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Sampled oscillator clock for the controller flops |
| rst_n | input | 1 | Reset pin, active low; asserts asynchronously and releases synchronously |
| halt_req | input | 1 | Halt flag write strobe |
| idle_req | input | 1 | Idle request strobe |
| wake_mi | input | 1 | Multi-input wakeup event |
| clkout_pin | input | 1 | Clock-output pin level; a rising edge wakes the block |
| clkmon_en | input | 1 | Clock monitor enabled |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Clock enable for the rest of the chip |
| t0_clk_en | output | 1 | Clock enable for timer T0 |
| wdog_dis | output | 1 | Watchdog disable |
| wdout_n | output | 1 | Watchdog output, driven low by the clock monitor in halt |

## Verification
Some properties are checked by the assertions on every cycle: the core clock never runs without the oscillator, the watchdog disable and the core clock are never on together, the watchdog output goes low only in halt with the monitor enabled, and requests made during settle leave the oscillator running. Other behaviour is shown only by the bench's scenarios: the exact 2560-edge settle length, the refusal of a pin level that was already high, the halt-over-idle priority, and the asynchronous exit through reset.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_HALT   = 2'd1,
    PS_SETTLE = 2'd2,
    PS_IDLE   = 2'd3
  } pstate_t;
endpackage

// File: rtl/hwc_wake_detect.sv
module hwc_wake_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic wake_mi,
  input  logic clkout_pin,
  output logic wake
);
  logic pin_q;
  logic pin_d;

  always_comb pin_d = clkout_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  always_comb wake = armed & (wake_mi | (clkout_pin & ~pin_q));
endmodule

// File: rtl/hwc_settle_timer.sv
module hwc_settle_timer #(
  parameter int DIV          = 10,
  parameter int SETTLE_COUNT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CW = $clog2(SETTLE_COUNT + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_COUNT);

  logic [DW-1:0] div_q, div_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick;

  always_comb begin
    tick  = run && (div_q == DIV_LAST);
    div_d = div_q;
    cnt_d = cnt_q;
    if (start) begin
      div_d = '0;
      cnt_d = CNT_LOAD;
    end else if (run) begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (start || run) begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb done = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/hwc_fsm.sv
module hwc_fsm
  import hwc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    halt_req,
  input  logic    idle_req,
  input  logic    wake,
  input  logic    settle_done,
  output pstate_t state,
  output logic    settle_start
);
  pstate_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_RUN: begin
        if (halt_req)      state_d = PS_HALT;
        else if (idle_req) state_d = PS_IDLE;
      end
      PS_HALT:   if (wake)        state_d = PS_SETTLE;
      PS_SETTLE: if (settle_done) state_d = PS_RUN;
      PS_IDLE:   if (wake)        state_d = PS_RUN;
      default:                    state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  always_comb begin
    state        = state_q;
    settle_start = (state_d == PS_SETTLE) && (state_q != PS_SETTLE);
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int DIV          = 10,
  parameter int SETTLE_COUNT = 256
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic idle_req,
  input  logic wake_mi,
  input  logic clkout_pin,
  input  logic clkmon_en,
  output logic osc_en,
  output logic core_clk_en,
  output logic t0_clk_en,
  output logic wdog_dis,
  output logic wdout_n
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pstate_t    state;
  logic       settle_start, settle_done, wake, armed;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_int_n = rst_sync_q[1];

  always_comb armed = (state == PS_HALT) || (state == PS_IDLE);

  hwc_wake_detect u_wake (
    .clk        (osc_clk),
    .rst_n      (rst_int_n),
    .armed      (armed),
    .wake_mi    (wake_mi),
    .clkout_pin (clkout_pin),
    .wake       (wake)
  );

  hwc_settle_timer #(.DIV(DIV), .SETTLE_COUNT(SETTLE_COUNT)) u_settle (
    .clk   (osc_clk),
    .rst_n (rst_int_n),
    .start (settle_start),
    .run   (state == PS_SETTLE),
    .done  (settle_done)
  );

  hwc_fsm u_fsm (
    .clk          (osc_clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req & rst_int_n),
    .idle_req     (idle_req & rst_int_n),
    .wake         (wake),
    .settle_done  (settle_done),
    .state        (state),
    .settle_start (settle_start)
  );

  always_comb begin
    osc_en      = 1'b1;
    core_clk_en = 1'b0;
    t0_clk_en   = 1'b0;
    wdog_dis    = 1'b0;
    unique case (state)
      PS_RUN:    begin core_clk_en = 1'b1; t0_clk_en = 1'b1; end
      PS_HALT:   begin osc_en = 1'b0; wdog_dis = 1'b1; end
      PS_SETTLE: wdog_dis = 1'b1;
      PS_IDLE:   t0_clk_en = 1'b1;
      default:   ;
    endcase
    wdout_n = !((state == PS_HALT) && clkmon_en);
  end
endmodule

// File: rtl/halt_wake_ctrl_chk.sv
module halt_wake_ctrl_chk (
  input logic osc_clk,
  input logic rst_n,
  input logic halt_req,
  input logic idle_req,
  input logic wake_mi,
  input logic clkmon_en,
  input logic osc_en,
  input logic core_clk_en,
  input logic t0_clk_en,
  input logic wdog_dis,
  input logic wdout_n
);
  logic in_settle, in_idle;
  always_comb begin
    in_settle = osc_en && !core_clk_en && !t0_clk_en;
    in_idle   = t0_clk_en && !core_clk_en;
  end

  p_core_needs_osc_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    core_clk_en |-> osc_en);
  p_wdog_core_excl_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wdog_dis |-> !core_clk_en);
  p_wdout_halt_only_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !wdout_n |-> (!osc_en && clkmon_en));
  p_release_after_osc_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(osc_en));
  p_settle_ignores_req_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (in_settle && (halt_req || idle_req)) |=> osc_en);
  p_idle_wake_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (in_idle && wake_mi) |=> core_clk_en);
endmodule

bind halt_wake_ctrl halt_wake_ctrl_chk u_chk (
  .osc_clk     (osc_clk),
  .rst_n       (rst_n),
  .halt_req    (halt_req),
  .idle_req    (idle_req),
  .wake_mi     (wake_mi),
  .clkmon_en   (clkmon_en),
  .osc_en      (osc_en),
  .core_clk_en (core_clk_en),
  .t0_clk_en   (t0_clk_en),
  .wdog_dis    (wdog_dis),
  .wdout_n     (wdout_n)
);

// File: tb/halt_wake_ctrl_tb_top.sv
module halt_wake_ctrl_tb_top;
  logic osc_clk = 1'b0;
  logic rst_n, halt_req, idle_req, wake_mi, clkout_pin, clkmon_en;
  logic osc_en, core_clk_en, t0_clk_en, wdog_dis, wdout_n;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  localparam logic [4:0] O_RUN    = 5'b11101;
  localparam logic [4:0] O_HALT   = 5'b00011;
  localparam logic [4:0] O_HALTM  = 5'b00010;
  localparam logic [4:0] O_SETTLE = 5'b10011;
  localparam logic [4:0] O_IDLE   = 5'b10101;
  localparam int SETTLE_EDGES = 2560;

  // {halt_req, idle_req, wake_mi, clkout_pin, clkmon_en, expected word}
  localparam int NV = 9;
  localparam logic [9:0] VEC [NV] = '{
    {5'b00000, O_RUN},    // R1 idle inputs stay running
    {5'b01000, O_IDLE},   // R7 enter idle
    {5'b00000, O_IDLE},   // R7 hold idle
    {5'b00100, O_RUN},    // R7 idle wake without settle
    {5'b11000, O_HALT},   // R2 halt beats idle
    {5'b00001, O_HALTM},  // R3 monitor pulls wdout low
    {5'b10001, O_HALTM},  // R8 halt_req in halt
    {5'b01000, O_HALT},   // R8 idle_req in halt ignored
    {5'b00010, O_SETTLE}  // R5 clkout rising edge wakes
  };

  always #5 osc_clk = ~osc_clk;

  halt_wake_ctrl dut_i (
    .osc_clk (osc_clk), .rst_n (rst_n), .halt_req (halt_req), .idle_req (idle_req),
    .wake_mi (wake_mi), .clkout_pin (clkout_pin), .clkmon_en (clkmon_en),
    .osc_en (osc_en), .core_clk_en (core_clk_en), .t0_clk_en (t0_clk_en),
    .wdog_dis (wdog_dis), .wdout_n (wdout_n)
  );

  function automatic logic [4:0] outw();
    return {osc_en, core_clk_en, t0_clk_en, wdog_dis, wdout_n};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input logic [4:0] ins);
    {halt_req, idle_req, wake_mi, clkout_pin, clkmon_en} = ins;
    @(posedge osc_clk);
    @(negedge osc_clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    {halt_req, idle_req, wake_mi, clkout_pin, clkmon_en} = '0;
    rst_n = 1'b0;
    #1;
    check("R1 reset word", outw(), O_RUN);
    repeat (3) @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge osc_clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][9:5]);
      check($sformatf("vector %0d", i), outw(), VEC[i][4:0]);
    end

    // R6 settle length, with R8 halt_req held during settle
    halt_req = 1'b1;
    clkout_pin = 1'b0;
    n = 0;
    while (n < 3000 && !core_clk_en) begin
      @(posedge osc_clk);
      @(negedge osc_clk);
      n++;
      if (n == 100) begin
        check("R8 halt_req ignored in settle", outw(), O_SETTLE);
        halt_req = 1'b0;
      end
      if (n == SETTLE_EDGES - 1) check("R6 not released early", outw(), O_SETTLE);
    end
    n_run++;
    if (n != SETTLE_EDGES) begin
      n_fail++;
      $display("FAIL R6: got %0d edges expected %0d", n, SETTLE_EDGES);
    end
    check("R6 running after settle", outw(), O_RUN);

    // R4 multi-input wakeup
    step(5'b10000);
    check("R2 halt entry", outw(), O_HALT);
    step(5'b00100);
    check("R4 wake_mi enters settle", outw(), O_SETTLE);
    step(5'b00000);
    check("R4 settle holds", outw(), O_SETTLE);

    // R1 reset from settle / halt, no settle needed
    rst_n = 1'b0;
    #1;
    check("R1 reset exits settle at once", outw(), O_RUN);
    @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge osc_clk);
    step(5'b10010);
    check("R5 halt with pin already high", outw(), O_HALT);
    step(5'b00010);
    check("R5 held level does not wake", outw(), O_HALT);
    step(5'b00000);
    check("R5 pin fall does not wake", outw(), O_HALT);
    rst_n = 1'b0;
    #1;
    check("R1 reset exits halt at once", outw(), O_RUN);
    @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge osc_clk);
    check("R3 wdout high outside halt", outw(), O_RUN);
    finish_run();
  end
endmodule